// File: doc/BRIEF.md
# Multi-Hart Machine Timer

This block is a memory-mapped machine timer shared by several harts. It keeps one 64-bit time counter and one 64-bit compare value for each hart. Each hart gets a level interrupt that stays high while its compare value is at or below the current time. The time counter advances by one on every clock where the tick-enable input is high.

Software reaches the registers through a simple register port that carries an address, a write flag, a size flag (4 or 8 bytes) and 64-bit write data. Read data comes back one clock later. A 4-byte access works on one half of a 64-bit register. An 8-byte access at a slot's base moves the whole register in one operation. Software can also write the time counter, and every hart's interrupt follows the new time at once.

The compare slots sit at `CMP_BASE + 8*h`, where h is the hart index. The time counter sits at `TIME_BASE`.

Top module: `mhart_timer`

## Requirements
- R1: Hart h's compare register is at `CMP_BASE + 8*h`, with its low half at byte offset 0 and its high half at offset 4. The time counter uses the same low/high layout at `TIME_BASE`. `req_wide`=1 means an 8-byte access and 0 means a 4-byte access.
- R2: A 4-byte read at offset 0 returns the low 32 bits in `rsp_rdata[31:0]`, and a 4-byte read at offset 4 returns the high 32 bits there. In both cases `rsp_rdata[63:32]` is zero.
- R3: An 8-byte read at offset 0 of a slot returns all 64 bits, all taken in the request cycle.
- R4: A 4-byte write to one half of a compare register (data in `req_wdata[31:0]`) changes only that half.
- R5: An 8-byte write at offset 0 of a compare slot replaces all 64 bits in one clock.
- R6: A 4-byte write to the low half of the time counter keeps its upper 32 bits. A 4-byte write to the high half keeps its lower 32 bits. An 8-byte write replaces the whole value.
- R7: `timer_irq[h]` is high exactly when hart h's compare value is less than or equal to the time, equality included. This holds from the cycle after any compare write.
- R8: After any write to the time counter, every hart's interrupt reflects the new time in the next cycle, both when it rises and when it falls.
- R9: The time counter increments by one on each clock with `tick_en` high and holds when `tick_en` is low. A software write to the time counter in the same cycle wins over the increment.
- R10: The following accesses are invalid: a hart index at or beyond `NUM_HARTS`, any offset other than 0 or 4 within a slot, an 8-byte access at offset 4, and time-counter offsets other than 0 or 4. Invalid writes change nothing. Invalid reads return zero.
- R11: `rsp_valid` is high exactly one clock after each read request. Write requests produce no response.
- R12: Reset clears the time counter to zero and sets every compare register to all-ones, so no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Advances the time counter by one when high |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data (4-byte writes use bits 31:0) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| timer_irq | output | NUM_HARTS | Level timer interrupt, one bit per hart |

## Verification
The assertions assume that `tick_en` and the request inputs are known and steady around each rising edge. They also assume that `TIME_BASE` lies outside the compare region, so that an access to the time counter can be recognised from its address alone. The bench drives every input on the falling edge. It uses the default map, where the time counter sits well above the last compare slot. It holds `tick_en` low except in the scenarios that test counting, so that the expected time values stay exact.

// File: rtl/mhart_timer.sv
module mhart_timer #(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CMP_BASE = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = 16'h0100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_wide,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [63:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [63:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] timer_irq
);
  localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(NUM_HARTS * 8);

  logic [63:0] mtime;
  logic [63:0] cmp [NUM_HARTS];

  logic [ADDR_W-1:0] cmp_off, time_off;
  logic [HART_W-1:0] hart_idx;
  logic              cmp_hit, cmp_hi, time_hit, time_hi;
  logic              wr, rd;
  logic [63:0]       rd_sel, rd_next;

  assign cmp_off  = req_addr - CMP_BASE;
  assign time_off = req_addr - TIME_BASE;
  assign hart_idx = cmp_off[HART_W+2:3];
  assign cmp_hi   = cmp_off[2:0] == 3'd4;
  assign cmp_hit  = (cmp_off < CMP_SPAN) &&
                    ((cmp_off[2:0] == 3'd0) || (cmp_hi && !req_wide));
  assign time_hi  = time_off == ADDR_W'(4);
  assign time_hit = (time_off == '0) || (time_hi && !req_wide);
  assign wr       = req_valid && req_write;
  assign rd       = req_valid && !req_write;

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] wd,
                                        input logic wide, input logic hi);
    if (wide)    return wd;
    else if (hi) return {wd[31:0], old[31:0]};
    else         return {old[63:32], wd[31:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mtime <= '0;
    else if (wr && time_hit)
      mtime <= merge(mtime, req_wdata, req_wide, time_hi);
    else if (tick_en)
      mtime <= mtime + 64'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < NUM_HARTS; h++) cmp[h] <= '1;
    end else if (wr && cmp_hit) begin
      for (int h = 0; h < NUM_HARTS; h++)
        if (hart_idx == HART_W'(h)) cmp[h] <= merge(cmp[h], req_wdata, req_wide, cmp_hi);
    end
  end

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_irq
    assign timer_irq[g] = cmp[g] <= mtime;
  end

  always_comb begin
    rd_sel = '0;
    for (int h = 0; h < NUM_HARTS; h++)
      if (hart_idx == HART_W'(h)) rd_sel = cmp[h];
    if (cmp_hit)
      rd_next = req_wide ? rd_sel : (cmp_hi ? {32'd0, rd_sel[63:32]} : {32'd0, rd_sel[31:0]});
    else if (time_hit)
      rd_next = req_wide ? mtime : (time_hi ? {32'd0, mtime[63:32]} : {32'd0, mtime[31:0]});
    else
      rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_next : '0;
    end
  end
endmodule

// File: rtl/mhart_timer_chk.sv
module mhart_timer_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TIME_BASE = 16'h0100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_wide,
  input logic [ADDR_W-1:0] req_addr,
  input logic [63:0]       req_wdata,
  input logic              rsp_valid,
  input logic [63:0]       rsp_rdata,
  input logic [63:0]       mtime
);
  logic time_addr, time_wr;
  assign time_addr = (req_addr == TIME_BASE) || (req_addr == TIME_BASE + ADDR_W'(4));
  assign time_wr   = req_valid && req_write && time_addr;

  // R9
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !time_wr) |=> mtime == $past(mtime) + 64'd1);

  // R9
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !time_wr) |=> $stable(mtime));

  // R6
  time_wide_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_wide && req_addr == TIME_BASE) |=> mtime == $past(req_wdata));

  // R11
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R11
  no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R2
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_wide) |=> rsp_rdata[63:32] == 32'd0);

  // R10
  bad_wide_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_wide && req_addr == TIME_BASE + ADDR_W'(4)) |=> rsp_rdata == 64'd0);
endmodule

bind mhart_timer mhart_timer_chk #(.ADDR_W(ADDR_W), .TIME_BASE(TIME_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
  .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mtime(mtime)
);

// File: tb/mhart_timer_bench.sv
`timescale 1ns/1ps
module mhart_timer_bench;
  localparam int N = 4;
  localparam logic [15:0] TB = 16'h0100;

  logic clk = 0, rst_n = 0, tick_en = 0;
  logic req_valid = 0, req_write = 0, req_wide = 0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid;
  logic [63:0] rsp_rdata;
  logic [N-1:0] timer_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mhart_timer #(.NUM_HARTS(N), .ADDR_W(16), .CMP_BASE(16'h0000), .TIME_BASE(TB)) u_mhart_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .timer_irq(timer_irq));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic wide, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_wide = wide; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic wide, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_wide = wide; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check("R11 rsp_valid after read", {63'd0, rsp_valid}, 64'd1);
    d = rsp_rdata;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R12 irq after reset", {60'd0, timer_irq}, 64'd0);
    bus_read(TB, 1, d);       check("R12 time reset", d, 64'd0);
    bus_read(16'h0000, 1, d); check("R12 cmp0 reset", d, '1);
    bus_read(16'h0018, 1, d); check("R12 cmp3 reset", d, '1);
  endtask

  task automatic t_cmp_halves;
    logic [63:0] d;
    bus_write(16'h0008, 1, 64'h1111_2222_3333_4444);
    bus_write(16'h0008, 0, 64'hFFFF_FFFF_AAAA_BBBB);
    bus_read(16'h0008, 1, d); check("R4 low half write", d, 64'h1111_2222_AAAA_BBBB);
    bus_write(16'h000C, 0, 64'h0000_0000_5555_6666);
    bus_read(16'h0008, 1, d); check("R4 high half write", d, 64'h5555_6666_AAAA_BBBB);
    bus_read(16'h0008, 0, d); check("R2 narrow low read", d, 64'h0000_0000_AAAA_BBBB);
    bus_read(16'h000C, 0, d); check("R2 narrow high read", d, 64'h0000_0000_5555_6666);
  endtask

  task automatic t_cmp_wide;
    logic [63:0] d;
    bus_write(16'h0010, 1, 64'h0123_4567_89AB_CDEF);
    bus_read(16'h0010, 1, d); check("R5 R3 wide write/read", d, 64'h0123_4567_89AB_CDEF);
    bus_read(16'h0000, 1, d); check("R1 neighbour slot untouched", d, '1);
  endtask

  task automatic t_time_halves;
    logic [63:0] d;
    bus_write(TB, 1, 64'h0000_0001_FFFF_FFF0);
    bus_read(TB, 1, d); check("R6 time wide write", d, 64'h0000_0001_FFFF_FFF0);
    bus_write(TB, 0, 64'hDEAD_0000_0000_0010);
    bus_read(TB, 1, d); check("R6 time low write", d, 64'h0000_0001_0000_0010);
    bus_write(TB + 16'd4, 0, 64'h0000_0000_0000_0007);
    bus_read(TB, 1, d); check("R6 time high write", d, 64'h0000_0007_0000_0010);
    bus_read(TB + 16'd4, 0, d); check("R2 time high read", d, 64'h0000_0000_0000_0007);
  endtask

  task automatic t_irq_cmp;
    bus_write(TB, 1, 64'd1000);
    bus_write(16'h0018, 1, 64'd1001);
    check("R7 cmp above time", {63'd0, timer_irq[3]}, 64'd0);
    bus_write(16'h0018, 1, 64'd1000);
    check("R7 cmp equal time", {63'd0, timer_irq[3]}, 64'd1);
    bus_write(16'h0018, 1, 64'd999);
    check("R7 cmp below time", {63'd0, timer_irq[3]}, 64'd1);
    bus_write(16'h0018, 1, 64'd1001);
    check("R7 cmp raised again", {63'd0, timer_irq[3]}, 64'd0);
  endtask

  task automatic t_irq_time;
    bus_write(16'h0000, 1, 64'd2000);
    bus_write(16'h0008, 1, 64'd3000);
    bus_write(TB, 1, 64'd2500);
    check("R8 time 2500", {60'd0, timer_irq}, 64'b1001);
    bus_write(TB, 1, 64'd3000);
    check("R8 time 3000", {60'd0, timer_irq}, 64'b1011);
    bus_write(TB, 1, 64'd10);
    check("R8 time back to 10", {60'd0, timer_irq}, 64'b0000);
    bus_write(TB + 16'd4, 0, 64'h0000_0000_0124_0000);
    check("R8 time high write", {60'd0, timer_irq}, 64'b1111);
  endtask

  task automatic t_tick;
    logic [63:0] d;
    bus_write(TB, 1, 64'd100);
    @(negedge clk); tick_en = 1;
    repeat (5) @(posedge clk);
    @(negedge clk); tick_en = 0;
    bus_read(TB, 1, d); check("R9 five ticks", d, 64'd105);
    tick_en = 1;
    bus_write(TB, 1, 64'd500);
    tick_en = 0;
    bus_read(TB, 1, d); check("R9 write beats tick", d, 64'd500);
    bus_write(TB, 1, 64'h0000_0000_FFFF_FFFF);
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0;
    bus_read(TB, 1, d); check("R9 carry into upper half", d, 64'h0000_0001_0000_0000);
  endtask

  task automatic t_invalid;
    logic [63:0] d;
    bus_write(TB, 1, 64'd50);
    bus_write(16'h0020, 1, 64'd1);
    bus_write(16'h0020, 0, 64'd1);
    bus_write(16'h000C, 1, 64'd1);
    bus_write(16'h0002, 0, 64'd1);
    bus_write(TB + 16'd4, 1, 64'd1);
    bus_write(TB + 16'd8, 0, 64'd1);
    check("R10 irq unchanged", {60'd0, timer_irq}, 64'b0000);
    bus_read(16'h0000, 1, d); check("R10 cmp0 kept", d, 64'd2000);
    bus_read(16'h0008, 1, d); check("R10 cmp1 kept", d, 64'd3000);
    bus_read(TB, 1, d);       check("R10 time kept", d, 64'd50);
    bus_read(16'h0020, 0, d); check("R10 bad hart read", d, 64'd0);
    bus_read(16'h000C, 1, d); check("R10 wide at +4 read", d, 64'd0);
    bus_read(16'h0005, 0, d); check("R10 odd offset read", d, 64'd0);
  endtask

  task automatic t_rsp_timing;
    bus_write(16'h0000, 1, 64'd2000);
    check("R11 no response to write", {63'd0, rsp_valid}, 64'd0);
    @(negedge clk);
    check("R11 idle no response", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cmp_halves();
    t_cmp_wide();
    t_time_halves();
    t_irq_cmp();
    t_irq_time();
    t_tick();
    t_invalid();
    t_rsp_timing();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule